// File: doc/BRIEF.md
# USB Device Endpoint Status Register

This block keeps the per-endpoint status of a four-endpoint USB device controller. There are two register views. The buffer-ready view can only be read. It shows which endpoint buffers the controller has primed and which it still holds. The completion view is write-one-to-clear. It records which endpoints have finished a transfer. Each view has a transmit half and a receive half. The controller datapath reports events to the block as single-cycle strobes: prime requests, flush requests, a bus reset, clears from the descriptor DMA engine, descriptor retirement and transfer completion.

Priming latency is modelled by an internal stub. The stub grants one pending prime at a time, lowest index first. Each grant takes a delay of `prime_lat` cycles. This makes the moment an endpoint turns ready depend on how many endpoints were primed together. The interrupt line is raised by any completion whose descriptor asked for interrupt-on-complete. It stays high until software clears those completions.

The register port is a plain single-cycle access with no handshake. A write takes effect at the clock edge where `reg_wen` is high. Reads are combinational from `reg_sel`. All event inputs are strobes with no back-pressure, so every strobe is accepted in the cycle it appears.

Top module: `usb_ep_status`

## Requirements
- R1: Both register views use the same word layout. Transmit endpoint i is at bit 16+i and receive endpoint i is at bit i. Every other bit reads 0. `reg_sel`=0 selects the ready view and `reg_sel`=1 selects the completion view.
- R2: After reset, both views read zero and `usb_irq` is low.
- R3: A ready bit is set only by a prime grant. A prime strobed alone at edge E0 makes the bit readable after edge E0+`prime_lat`+1.
- R4: Pending primes are granted one at a time in index order: receive 0..3, then transmit 0..3. The k-th granted bit (k from 0) turns ready after edge E0+`prime_lat`+1+k·(`prime_lat`+1).
- R5: A flush strobe, a DMA clear strobe or `bus_reset` clears the matching ready bits at the next edge. `bus_reset` clears all of them.
- R6: A retire strobe on a ready bit makes it read 0 for exactly one cycle, then 1 again.
- R7: A flush (or bus reset) that arrives while a prime is still pending cancels that prime, so its ready bit never sets.
- R8: A done strobe sets the completion bit at the next edge. If `ioc_*` is high with it, `usb_irq` rises at the same edge.
- R9: Writing 1 to a completion bit clears it. Writing 0 leaves it unchanged. Writes to the ready view change nothing.
- R10: If a done strobe and a write-1 clear hit the same completion bit in the same cycle, the bit stays set.
- R11: `usb_irq` is the OR of the completion bits whose events carried the ioc flag. A completion without ioc never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prime_lat | input | 4 | Stub grant delay in cycles (0 treated as 1) |
| bus_reset | input | 1 | USB bus reset strobe |
| prime_tx | input | 4 | Transmit prime request strobes |
| prime_rx | input | 4 | Receive prime request strobes |
| flush_tx | input | 4 | Transmit flush strobes |
| flush_rx | input | 4 | Receive flush strobes |
| dma_clr_tx | input | 4 | Transmit ready clear from DMA engine |
| dma_clr_rx | input | 4 | Receive ready clear from DMA engine |
| retire_tx | input | 4 | Transmit descriptor retire / re-prime strobes |
| retire_rx | input | 4 | Receive descriptor retire / re-prime strobes |
| done_tx | input | 4 | Transmit transfer-complete strobes |
| done_rx | input | 4 | Receive transfer-complete strobes |
| ioc_tx | input | 4 | Interrupt-on-complete flag for done_tx |
| ioc_rx | input | 4 | Interrupt-on-complete flag for done_rx |
| reg_sel | input | 1 | View select: 0 ready, 1 completion |
| reg_wen | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| usb_irq | output | 1 | USB interrupt |

## Verification
Two pairs of functions can collide in one cycle.

The first pair is a completion event and a software write-1 clear on the same bit. The bench strobes done and writes that bit's 1 in one cycle. It then expects the bit to read back set, and `usb_irq` to follow the ioc flag.

The second pair is a flush and a pending prime grant. The bench flushes an endpoint one cycle after priming it alongside another endpoint. It expects the flushed bit never to appear. It also expects the surviving endpoint to take the first grant slot, which the bench computes from `prime_lat`.

// File: rtl/usb_ep_status_pkg.sv
package usb_ep_status_pkg;
  // bit offset of the transmit half inside each register word
  localparam int TX_LSB = 16;
  localparam int WORD_W = 32;

  typedef enum logic {
    SEL_READY    = 1'b0,
    SEL_COMPLETE = 1'b1
  } view_sel_e;
endpackage

// File: rtl/ep_prime_stub.sv
module ep_prime_stub #(
  parameter int NB    = 8,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    prime,
  input  logic [NB-1:0]    cancel,
  input  logic [LAT_W-1:0] lat,
  output logic [NB-1:0]    ack
);
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0]    pend;
  logic             busy;
  logic [IDX_W-1:0] cur;
  logic [LAT_W-1:0] cnt;
  logic [IDX_W-1:0] pick;
  logic             found;
  logic             fire;
  logic             abort;
  logic [NB-1:0]    cand;

  // lowest-index pending prime that is not being cancelled now
  always_comb begin
    cand  = pend & ~cancel;
    pick  = '0;
    found = |cand;
    for (int i = NB - 1; i >= 0; i--) begin
      if (cand[i]) pick = IDX_W'(i);
    end
  end

  assign abort = busy && cancel[cur];
  assign fire  = busy && (cnt == LAT_W'(1)) && !cancel[cur];

  always_comb begin
    ack = '0;
    if (fire) ack[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      busy <= 1'b0;
      cur  <= '0;
      cnt  <= '0;
    end else begin
      pend <= ((pend & ~ack) | prime) & ~cancel;
      if (busy) begin
        if (abort || cnt == LAT_W'(1)) busy <= 1'b0;
        else                           cnt  <= cnt - LAT_W'(1);
      end else if (found) begin
        busy <= 1'b1;
        cur  <= pick;
        cnt  <= (lat == '0) ? LAT_W'(1) : lat;
      end
    end
  end

  // R4: grants are served one endpoint at a time
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  // R7: a cancelled prime is not granted right after the cancel
  a_r7_cancel_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel != '0) |=> ((ack & $past(cancel)) == '0));
endmodule

// File: rtl/ep_ready_bank.sv
module ep_ready_bank #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] ack,
  input  logic [NB-1:0] clear,
  input  logic [NB-1:0] retire,
  output logic [NB-1:0] rdy
);
  logic [NB-1:0] reprime_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy       <= '0;
      reprime_q <= '0;
    end else begin
      reprime_q <= retire & rdy & ~clear;
      rdy       <= ((rdy & ~retire) | ack | reprime_q) & ~clear;
    end
  end

  // R5: any clear source empties the bit at the next edge
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clear != '0) |=> ((rdy & $past(clear)) == '0));

  // R6: a retire on a ready bit makes it dip to zero
  a_r6_retire_dip: assert property (@(posedge clk) disable iff (!rst_n)
    ((retire & rdy & ~clear) != '0) |=> ((rdy & $past(retire & rdy & ~clear)) == '0));

  // R3: a ready bit rises only from a grant or a re-prime
  a_r3_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rdy & ~$past(rdy) & ~$past(ack | reprime_q)) == '0));
endmodule

// File: rtl/ep_complete_bank.sv
module ep_complete_bank #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] done,
  input  logic [NB-1:0] ioc,
  input  logic [NB-1:0] w1c,
  output logic [NB-1:0] comp,
  output logic          irq
);
  logic [NB-1:0] ioc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp  <= '0;
      ioc_q <= '0;
    end else begin
      comp  <= (comp & ~w1c) | done;
      ioc_q <= (ioc_q & ~w1c) | (done & ioc);
    end
  end

  assign irq = |(comp & ioc_q);

  // R9: a write-1 without a new event clears the bit
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((w1c & ~done) != '0) |=> ((comp & $past(w1c & ~done)) == '0));

  // R10: an event beats a simultaneous clear
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |=> ((comp & $past(done)) == $past(done)));

  // R8: an event with ioc raises the interrupt at the same edge as the bit
  a_r8_irq_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ioc) != '0) |=> irq);

  // R11: the interrupt holds while software writes nothing
  a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && w1c == '0) |=> irq);
endmodule

// File: rtl/usb_ep_status.sv
module usb_ep_status
  import usb_ep_status_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  prime_lat,
  input  logic              bus_reset,
  input  logic [NUM_EP-1:0] prime_tx,
  input  logic [NUM_EP-1:0] prime_rx,
  input  logic [NUM_EP-1:0] flush_tx,
  input  logic [NUM_EP-1:0] flush_rx,
  input  logic [NUM_EP-1:0] dma_clr_tx,
  input  logic [NUM_EP-1:0] dma_clr_rx,
  input  logic [NUM_EP-1:0] retire_tx,
  input  logic [NUM_EP-1:0] retire_rx,
  input  logic [NUM_EP-1:0] done_tx,
  input  logic [NUM_EP-1:0] done_rx,
  input  logic [NUM_EP-1:0] ioc_tx,
  input  logic [NUM_EP-1:0] ioc_rx,
  input  logic              reg_sel,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              usb_irq
);
  // internal order: receive endpoints at 0..NUM_EP-1, transmit above them
  localparam int NB = 2 * NUM_EP;
  localparam logic [31:0] LIVE_MASK =
    32'(((64'd1 << NUM_EP) - 1) | (((64'd1 << NUM_EP) - 1) << TX_LSB));

  logic [NB-1:0] ack, clear, rdy, comp, w1c;
  view_sel_e     sel;

  assign sel   = view_sel_e'(reg_sel);
  assign clear = {flush_tx | dma_clr_tx, flush_rx | dma_clr_rx} | {NB{bus_reset}};
  assign w1c   = (reg_wen && sel == SEL_COMPLETE)
               ? {reg_wdata[TX_LSB +: NUM_EP], reg_wdata[0 +: NUM_EP]} : '0;

  ep_prime_stub #(.NB(NB), .LAT_W(LAT_W)) stub_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .prime  ({prime_tx, prime_rx}),
    .cancel (clear),
    .lat    (prime_lat),
    .ack    (ack)
  );

  ep_ready_bank #(.NB(NB)) ready_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack    (ack),
    .clear  (clear),
    .retire ({retire_tx, retire_rx}),
    .rdy    (rdy)
  );

  ep_complete_bank #(.NB(NB)) comp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .done  ({done_tx, done_rx}),
    .ioc   ({ioc_tx, ioc_rx}),
    .w1c   (w1c),
    .comp  (comp),
    .irq   (usb_irq)
  );

  always_comb begin
    logic [NB-1:0] src;
    src       = (sel == SEL_READY) ? rdy : comp;
    reg_rdata = '0;
    reg_rdata[0 +: NUM_EP]      = src[0 +: NUM_EP];
    reg_rdata[TX_LSB +: NUM_EP] = src[NUM_EP +: NUM_EP];
  end

  // R1: bits outside the two endpoint fields read zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~LIVE_MASK) == '0));

  // R2: status is empty on the first cycle after reset
  a_r2_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (rdy == '0 && comp == '0));
endmodule

// File: tb/usb_ep_status_tb_top.sv
module usb_ep_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  prime_lat = 4'd1;
  logic        bus_reset = 1'b0;
  logic [3:0]  prime_tx = '0, prime_rx = '0, flush_tx = '0, flush_rx = '0;
  logic [3:0]  dma_clr_tx = '0, dma_clr_rx = '0, retire_tx = '0, retire_rx = '0;
  logic [3:0]  done_tx = '0, done_rx = '0, ioc_tx = '0, ioc_rx = '0;
  logic        reg_sel = 1'b0, reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        usb_irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  usb_ep_status dut_i (
    .clk(clk), .rst_n(rst_n), .prime_lat(prime_lat), .bus_reset(bus_reset),
    .prime_tx(prime_tx), .prime_rx(prime_rx), .flush_tx(flush_tx), .flush_rx(flush_rx),
    .dma_clr_tx(dma_clr_tx), .dma_clr_rx(dma_clr_rx),
    .retire_tx(retire_tx), .retire_rx(retire_rx),
    .done_tx(done_tx), .done_rx(done_rx), .ioc_tx(ioc_tx), .ioc_rx(ioc_rx),
    .reg_sel(reg_sel), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .usb_irq(usb_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  // internal index i: 0..3 receive, 4..7 transmit
  function automatic logic [31:0] place(input int i);
    return (i < 4) ? (32'd1 << i) : (32'd1 << (16 + i - 4));
  endfunction

  task automatic wr_cmp(input logic [31:0] d);
    reg_sel = 1'b1; reg_wen = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_bus_reset();
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, e;
    int t[8];
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    rd(1'b0, v); chk("R2 ready reset", v, 32'h0);
    rd(1'b1, v); chk("R2 complete reset", v, 32'h0);
    chk("R2 irq reset", {31'h0, usb_irq}, 32'h0);

    // R3 R4 R1: sweep every prime subset for several latencies
    for (int lat = 1; lat <= 4; lat++) begin
      prime_lat = 4'(lat);
      for (int mask = 1; mask < 256; mask++) begin
        int k;
        int last;
        pulse_bus_reset();
        k = 0; last = 0;
        for (int i = 0; i < 8; i++) begin
          if (mask[i]) begin
            t[i] = lat + 2 + k * (lat + 1);
            last = t[i];
            k++;
          end else t[i] = 1 << 30;
        end
        prime_rx = mask[3:0]; prime_tx = mask[7:4];
        @(negedge clk);
        prime_rx = '0; prime_tx = '0;
        for (int m = 1; m <= last + 1; m++) begin
          e = '0;
          for (int i = 0; i < 8; i++) if (t[i] <= m) e |= place(i);
          rd(1'b0, v);
          chk("R4 grant order R3 latency R1 layout", v, e);
          @(negedge clk);
        end
      end
    end

    // R9 ready view ignores writes (all ready bits set from last sweep)
    rd(1'b0, e);
    reg_sel = 1'b0; reg_wen = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wen = 1'b0;
    rd(1'b0, v); chk("R9 ready write ignored", v, e);
    rd(1'b1, v); chk("R9 ready write leaves completion", v, 32'h0);

    // R6 retire dip on transmit 2: one cycle low, then back
    retire_tx = 4'b0100;
    @(negedge clk);
    retire_tx = '0;
    rd(1'b0, v); chk("R6 retire dip", v, e & ~place(6));
    @(negedge clk);
    rd(1'b0, v); chk("R6 retire return", v, e);

    // R5 clear sources
    flush_tx = 4'b0010; dma_clr_rx = 4'b1000;
    @(negedge clk);
    flush_tx = '0; dma_clr_rx = '0;
    rd(1'b0, v); chk("R5 flush and dma clear", v, e & ~place(5) & ~place(3));
    pulse_bus_reset();
    rd(1'b0, v); chk("R5 bus reset clears all", v, 32'h0);

    // R7 flush cancels pending prime; survivor takes first slot
    for (int lat = 1; lat <= 3; lat++) begin
      prime_lat = 4'(lat);
      pulse_bus_reset();
      prime_rx = 4'b0100; prime_tx = 4'b0001;
      @(negedge clk);
      prime_rx = '0; prime_tx = '0; flush_rx = 4'b0100;
      @(negedge clk);
      flush_rx = '0;
      for (int m = 2; m <= 3 * (lat + 2); m++) begin
        e = (m >= lat + 2) ? place(4) : 32'h0;
        rd(1'b0, v); chk("R7 flush cancels pending prime", v, e);
        @(negedge clk);
      end
    end

    // R8 R11 R9: each completion bit, with and without ioc
    for (int i = 0; i < 8; i++) begin
      for (int f = 0; f < 2; f++) begin
        logic [7:0] b;
        b = 8'(1 << i);
        done_rx = b[3:0]; done_tx = b[7:4];
        ioc_rx = f ? b[3:0] : '0; ioc_tx = f ? b[7:4] : '0;
        @(negedge clk);
        done_rx = '0; done_tx = '0; ioc_rx = '0; ioc_tx = '0;
        rd(1'b1, v); chk("R8 completion bit set", v, place(i));
        chk("R8 R11 irq follows ioc", {31'h0, usb_irq}, 32'(f));
        wr_cmp(~place(i));
        rd(1'b1, v); chk("R9 write zero keeps bit", v, place(i));
        chk("R11 irq held", {31'h0, usb_irq}, 32'(f));
        wr_cmp(place(i));
        rd(1'b1, v); chk("R9 write one clears", v, 32'h0);
        chk("R11 irq drops", {31'h0, usb_irq}, 32'h0);
      end
    end

    // R10 event and clear in the same cycle
    done_tx = 4'b1000; ioc_tx = 4'b1000;
    @(negedge clk);
    done_tx = '0; ioc_tx = '0;
    done_tx = 4'b1000; ioc_tx = 4'b1000;
    reg_sel = 1'b1; reg_wen = 1'b1; reg_wdata = place(7);
    @(negedge clk);
    done_tx = '0; ioc_tx = '0; reg_wen = 1'b0; reg_wdata = '0;
    rd(1'b1, v); chk("R10 event beats clear", v, place(7));
    chk("R10 irq kept", {31'h0, usb_irq}, 32'h1);

    // R11 irq only from ioc bits: ioc rx0 and plain rx1, clear ioc one
    done_rx = 4'b0011; ioc_rx = 4'b0001;
    @(negedge clk);
    done_rx = '0; ioc_rx = '0;
    wr_cmp(place(7) | place(0));
    rd(1'b1, v); chk("R11 plain bit left", v, place(1));
    chk("R11 irq low without ioc", {31'h0, usb_irq}, 32'h0);

    finish_run();
  end
endmodule